// File: doc/BRIEF.md
# Burst Address Generator with Repeat

This block generates the address for one port of a banked memory. The address is a single word. Its upper field selects a bank and its lower field is the offset inside that bank. On each rising clock edge the block does one of four things. It can take an address from outside, step its stored address up by one, jump back to a remembered start address, or keep its value. The result appears on the output and is the address the port uses in the cycle that follows the edge.

The remembered start address is written only by an external load. A burst engine can therefore start at a base, count through a block of words and return to the base with a single strobe. It does not need to drive the base again. Counting treats bank and offset as one number, so a burst runs across bank edges without a break. Memory enables and byte lanes do not touch this unit. All of its strobes are active low.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, the address output is zero and the error output is low. Reset also forgets the stored repeat address, so the repeat address becomes invalid again.
- R2: When `load_n` is low (and `repeat_n` is high) at a rising edge, `addr` equals `ext_addr` after that edge. That value is also stored as the repeat address.
- R3: When `load_n` and `repeat_n` are high and `count_n` is low at an edge, `addr` becomes its previous value plus one, modulo 2^(BANK_W+OFS_W).
- R4: When `load_n`, `count_n` and `repeat_n` are all high at an edge, `addr` keeps its value and `ext_addr` has no effect.
- R5: Counting from the last offset of a bank (offset field all ones, bank k) gives offset zero of bank k+1.
- R6: Counting from the last offset of the last bank (all address bits one) gives address zero.
- R7: When `repeat_n` is low and a repeat address is valid, `addr` becomes the address stored by the most recent load.
- R8: The priority is repeat, then load, then count, then hold. A load that shares its edge with a repeat neither drives `addr` nor updates the stored repeat address.
- R9: When `repeat_n` is low and no load has happened since reset, `addr` keeps its value and `rpt_err` is high for exactly the one cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | BANK_W+OFS_W | External address; bank in the upper bits |
| load_n | input | 1 | Active-low load strobe |
| count_n | input | 1 | Active-low count enable |
| repeat_n | input | 1 | Active-low return to stored load address |
| addr | output | BANK_W+OFS_W | Address in use for the current cycle |
| rpt_err | output | 1 | One-cycle flag: repeat requested with no valid stored address |

## Verification
Both outputs come from registers. Each result is due one clock edge after the edge that samples its strobes, and the error flag lasts a single cycle. The bench changes its inputs on the falling edge and reads the outputs on the next falling edge. Each vector's expected value therefore refers to exactly one rising edge. When the bench checks that a stored value was left alone, it uses a later repeat strobe and reads the result from the address that comes back.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   typedef enum logic [2:0] {
      OP_HOLD       = 3'd0,
      OP_STEP       = 3'd1,
      OP_TAKE_EXT   = 3'd2,
      OP_RECALL     = 3'd3,
      OP_RECALL_BAD = 3'd4
   } addr_op_e;

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
   import burst_addr_pkg::*;
(
   input  logic     load_n,
   input  logic     count_n,
   input  logic     repeat_n,
   input  logic     base_valid,
   output addr_op_e op
);

   always_comb begin
      if (!repeat_n) begin
         op = base_valid ? OP_RECALL : OP_RECALL_BAD;
      end else if (!load_n) begin
         op = OP_TAKE_EXT;
      end else if (!count_n) begin
         op = OP_STEP;
      end else begin
         op = OP_HOLD;
      end
   end

endmodule

// File: rtl/burst_base_store.sv
module burst_base_store #(
   parameter int unsigned AW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [AW-1:0] din,
   output logic [AW-1:0] base_q,
   output logic          valid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         valid_q <= 1'b0;
      end else if (capture) begin
         base_q  <= din;
         valid_q <= 1'b1;
      end
   end

endmodule

// File: rtl/burst_step_unit.sv
module burst_step_unit #(
   parameter int unsigned BANK_W      = 6,
   parameter int unsigned OFS_W       = 12,
   parameter bit          SPLIT_CARRY = 1'b1
) (
   input  logic [BANK_W+OFS_W-1:0] cur,
   output logic [BANK_W+OFS_W-1:0] nxt
);

   localparam int unsigned AW = BANK_W + OFS_W;

   generate
      if (SPLIT_CARRY) begin : g_split
         logic [OFS_W:0]    ofs_sum;
         logic [BANK_W-1:0] bank_sum;
         always_comb begin
            ofs_sum  = {1'b0, cur[OFS_W-1:0]} + {{OFS_W{1'b0}}, 1'b1};
            bank_sum = cur[AW-1:OFS_W] + {{(BANK_W-1){1'b0}}, ofs_sum[OFS_W]};
            nxt      = {bank_sum, ofs_sum[OFS_W-1:0]};
         end
      end else begin : g_flat
         always_comb begin
            nxt = cur + {{(AW-1){1'b0}}, 1'b1};
         end
      end
   endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int unsigned BANK_W      = 6,
   parameter int unsigned OFS_W       = 12,
   parameter bit          SPLIT_CARRY = 1'b1,
   localparam int unsigned AW         = BANK_W + OFS_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ext_addr,
   input  logic          load_n,
   input  logic          count_n,
   input  logic          repeat_n,
   output logic [AW-1:0] addr,
   output logic          rpt_err
);

   generate
      if (BANK_W < 2) begin : g_bad_bank
         $error("burst_addr_gen: BANK_W must be at least 2");
      end
      if (OFS_W < 1) begin : g_bad_ofs
         $error("burst_addr_gen: OFS_W must be at least 1");
      end
   endgenerate

   addr_op_e      op;
   logic [AW-1:0] base_q;
   logic          base_valid;
   logic [AW-1:0] step_addr;
   logic [AW-1:0] addr_q;
   logic          err_q;

   burst_op_decode u_decode (
      .load_n     (load_n),
      .count_n    (count_n),
      .repeat_n   (repeat_n),
      .base_valid (base_valid),
      .op         (op)
   );

   burst_base_store #(.AW(AW)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (op == OP_TAKE_EXT),
      .din     (ext_addr),
      .base_q  (base_q),
      .valid_q (base_valid)
   );

   burst_step_unit #(
      .BANK_W      (BANK_W),
      .OFS_W       (OFS_W),
      .SPLIT_CARRY (SPLIT_CARRY)
   ) u_step (
      .cur (addr_q),
      .nxt (step_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= (op == OP_RECALL_BAD);
         unique case (op)
            OP_TAKE_EXT: addr_q <= ext_addr;
            OP_STEP:     addr_q <= step_addr;
            OP_RECALL:   addr_q <= base_q;
            default:     addr_q <= addr_q;
         endcase
      end
   end

   assign addr    = addr_q;
   assign rpt_err = err_q;

   // R2
   load_takes_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (repeat_n && !load_n) |=> (addr == $past(ext_addr)));

   // R3
   count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (repeat_n && load_n && !count_n) |=> (addr == AW'($past(addr) + 1'b1)));

   // R4
   idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (repeat_n && load_n && count_n) |=> $stable(addr));

   // R7
   recall_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!repeat_n && base_valid) |=> (addr == $past(base_q)));

   // R9
   recall_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!repeat_n && !base_valid) |=> (rpt_err && $stable(addr)));

   // R9
   err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!repeat_n && !base_valid) |=> !rpt_err);

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

   localparam int AW = 18;
   localparam int VW = 3 + AW + AW + 1;
   localparam int NV = 15;

   // {load_n, count_n, repeat_n, ext_addr, expected addr, expected err}
   localparam logic [VW-1:0] VEC [NV] = '{
      {3'b110, 18'h00000, 18'h00000, 1'b1},  // R9 repeat before any load
      {3'b101, 18'h00000, 18'h00001, 1'b0},  // R3 count
      {3'b011, 18'h00FFE, 18'h00FFE, 1'b0},  // R2 load
      {3'b101, 18'h00000, 18'h00FFF, 1'b0},  // R3
      {3'b101, 18'h00000, 18'h01000, 1'b0},  // R5 bank carry
      {3'b111, 18'h2AAAA, 18'h01000, 1'b0},  // R4 hold, ext ignored
      {3'b110, 18'h00000, 18'h00FFE, 1'b0},  // R7 repeat
      {3'b011, 18'h3FFFF, 18'h3FFFF, 1'b0},  // R2
      {3'b101, 18'h00000, 18'h00000, 1'b0},  // R6 top wrap
      {3'b010, 18'h12345, 18'h3FFFF, 1'b0},  // R8 repeat beats load
      {3'b101, 18'h00000, 18'h00000, 1'b0},  // R6
      {3'b110, 18'h00000, 18'h3FFFF, 1'b0},  // R8 base not overwritten
      {3'b001, 18'h12345, 18'h12345, 1'b0},  // R8 load beats count
      {3'b101, 18'h00000, 18'h12346, 1'b0},  // R3
      {3'b100, 18'h00000, 18'h12345, 1'b0}   // R8 repeat beats count
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          load_n = 1'b1;
   logic          count_n = 1'b1;
   logic          repeat_n = 1'b1;
   logic [AW-1:0] addr;
   logic          rpt_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   burst_addr_gen dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_addr (ext_addr),
      .load_n   (load_n),
      .count_n  (count_n),
      .repeat_n (repeat_n),
      .addr     (addr),
      .rpt_err  (rpt_err)
   );

   task automatic check(input string req, input logic [AW-1:0] ea, input logic ee);
      checks++;
      if (addr !== ea || rpt_err !== ee) begin
         fails++;
         $display("FAIL %s: addr=%h err=%b expected addr=%h err=%b", req, addr, rpt_err, ea, ee);
      end
   endtask

   task automatic drive(input logic [2:0] ctl, input logic [AW-1:0] ea);
      {load_n, count_n, repeat_n} = ctl;
      ext_addr = ea;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state", '0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][VW-1 -: 3], VEC[i][VW-4 -: AW]);
         check($sformatf("vector %0d (R2-R9 table)", i), VEC[i][AW:1], VEC[i][0]);
      end

      // R9: flag lasts one cycle
      drive(3'b111, '0);
      check("R9 flag clears", 18'h12345, 1'b0);

      // R1: reset mid-run clears address and forgets the base
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run", '0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      drive(3'b110, '0);
      check("R1 base invalid after reset", '0, 1'b1);

      // R5: carry at a middle bank
      drive(3'b011, 18'h1EFFF);
      drive(3'b101, '0);
      check("R5 bank 30 to 31", 18'h1F000, 1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule